// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block holds the sticky status flags of an I2C controller and turns them into two interrupt lines. A protocol engine, which lies outside this block, reports what happened on the bus as one-cycle set pulses. Those pulses cover a start condition that has gone out, an address that has been sent, a byte transfer that has finished, a transmit holding register that is empty, a receive holding register that has data, a missing acknowledge, lost arbitration and a bus error. The engine also drives a level that says whether the bus is busy. Each pulse sets a flag that stays set until software clears it by the rule that belongs to that flag.

Software reaches the block through a simple register bus. It has a write strobe and a read strobe that each last one cycle, an address, and write data. Read data is combinational from the address, so the strobe only carries the side effects of a read. A control register holds three interrupt enables (buffer, event and error) and a six-bit field for the input clock frequency. The event line covers start, address and byte-finished. Transmit-empty and receive-not-empty add to the event line only when the buffer enable is also set. The error line carries the three error flags.

The flags clear in three ways. An error flag clears when a zero is written to its bit. The address flag clears after a status-1 read followed by a status-2 read. The start flag clears after a status-1 read followed by a data-register write. The data flags clear when the data register is accessed.

Top module: `i2c_status_irq`

## Requirements
- R1: After a synchronous active-low reset, both status registers read zero apart from the live busy bit, the control register reads zero, tx_data is zero, and both interrupt lines are low.
- R2: A set pulse makes its flag visible in status register 1 from the next cycle. The flag stays set until its own clear rule applies. The bit positions are: acknowledge failure 10, arbitration lost 9, bus error 8, transmit empty 7, receive not empty 6, byte finished 2, address sent 1, start sent 0. All other bits read zero.
- R3: Status register 2 (offset 0x18) shows the bus_busy input at bit 1. All other bits read zero.
- R4: Control register 2 (offset 0x04) stores the buffer enable at bit 10, the event enable at bit 9, the error enable at bit 8 and the clock frequency at bits 5:0, and reads them back. Other bits read zero. It changes only when it is written.
- R5: irq_event is high exactly when the event enable is set and at least one of these holds: start, address or byte-finished is set, or the buffer enable is set and transmit-empty or receive-not-empty is set.
- R6: irq_error is high exactly when the error enable is set and acknowledge failure, arbitration lost or bus error is set.
- R7: A write to status register 1 (offset 0x14) clears each error flag whose bit is written 0 and leaves it unchanged where the bit is written 1. The write has no effect on the event and data flags.
- R8: The address flag clears on a status-2 read that follows a status-1 read made while the flag was set. A status-2 read without that earlier status-1 read leaves the flag set.
- R9: The start flag clears on a data-register write that follows a status-1 read made while the flag was set. A data-register write without that earlier read leaves the flag set.
- R10: A data-register write clears transmit-empty, a data-register read clears receive-not-empty, and either access clears byte-finished.
- R11: When a set pulse and a clear of the same flag fall in the same cycle, the flag is left set.
- R12: A read of the data register (offset 0x10) returns rx_data in bits 7:0. A write loads bits 7:0 onto tx_data. Offsets with no register behind them read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle; carries only the side effects of a read |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| set_sb | input | 1 | Pulse: start condition sent |
| set_addr | input | 1 | Pulse: address sent |
| set_btf | input | 1 | Pulse: byte transfer finished |
| set_txe | input | 1 | Pulse: transmit holding register empty |
| set_rxne | input | 1 | Pulse: receive holding register full |
| set_af | input | 1 | Pulse: acknowledge failure |
| set_arlo | input | 1 | Pulse: arbitration lost |
| set_berr | input | 1 | Pulse: bus error |
| bus_busy | input | 1 | Level: bus is busy |
| rx_data | input | 8 | Received byte, returned on a data-register read |
| tx_data | output | 8 | Byte last written to the data register |
| irq_event | output | 1 | Event interrupt |
| irq_error | output | 1 | Error interrupt |

## Verification
The bench goes after the gating of the buffer flags. A design that let transmit-empty or receive-not-empty reach irq_event without the buffer enable would raise a spurious interrupt in the vectors that set only those flags. It also tests the two-step clear sequences by making the second access alone first. A design that cleared the address flag on any status-2 read, or the start flag on any data write, would lose the flag too early. The write-zero-to-clear rule is tested with mixed ones and zeros, which exposes a design that treats a 1 as a clear or that lets the write disturb the data flags. Finally, a set pulse is placed in the same cycle as a clear, which catches a design that gives priority to the clear and drops an event.

// File: rtl/i2c_sif_pkg.sv
// Package: shared offsets, bit positions and types for the I2C status and
// interrupt flag unit. Assumes byte offsets and a data word of at least 11 bits.
package i2c_sif_pkg;

    // Register byte offsets
    localparam int OFS_CTRL2 = 'h04;
    localparam int OFS_DATA  = 'h10;
    localparam int OFS_STAT1 = 'h14;
    localparam int OFS_STAT2 = 'h18;

    // Status register 1 bit positions
    localparam int B_AF   = 10;
    localparam int B_ARLO = 9;
    localparam int B_BERR = 8;
    localparam int B_TXE  = 7;
    localparam int B_RXNE = 6;
    localparam int B_BTF  = 2;
    localparam int B_ADDR = 1;
    localparam int B_SB   = 0;

    // Status register 2 bit position
    localparam int B_BUSY = 1;

    // Control register 2 bit positions
    localparam int B_BUFEN = 10;
    localparam int B_EVTEN = 9;
    localparam int B_ERREN = 8;
    localparam int FREQ_W  = 6;

    // Number of error flags
    localparam int N_ERR = 3;

    // Error flag vector, index order {af, arlo, berr}
    typedef logic [N_ERR-1:0] err_vec_t;

    // Control register 2 contents
    typedef struct packed {
        logic              buf_en;
        logic              evt_en;
        logic              err_en;
        logic [FREQ_W-1:0] freq;
    } ctrl2_t;

endpackage

// File: rtl/sif_err_flags.sv
// Error flags: a set pulse makes a flag sticky. A write to status register 1
// clears each flag whose write bit is 0. A set in the same cycle wins.
// Assumes keep_vec is the write data taken at each flag's bit position.
module sif_err_flags
    import i2c_sif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  err_vec_t set_vec,
    input  logic     wr_stat1,
    input  err_vec_t keep_vec,
    output err_vec_t q
);

    genvar g;
    generate
        for (g = 0; g < N_ERR; g++) begin : g_flag
            // One sticky flag, cleared by writing zero
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[g] <= 1'b0;
                else if (set_vec[g])
                    q[g] <= 1'b1;
                else if (wr_stat1 && !keep_vec[g])
                    q[g] <= 1'b0;
            end

            AST_ERR_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                wr_stat1 && !keep_vec[g] && !set_vec[g] |=> !q[g]); // R7
            AST_ERR_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                q[g] && !(wr_stat1 && !keep_vec[g]) |=> q[g]); // R7
        end
    endgenerate

endmodule

// File: rtl/sif_evt_flags.sv
// Event and data flags, each with its own clear rule. Address clears on a
// status-2 read once a status-1 read has seen it set. Start clears on a data
// write once a status-1 read has seen it set. Transmit-empty clears on a data
// write, receive-not-empty on a data read, byte-finished on either.
// A set pulse wins over a clear in the same cycle.
module sif_evt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_sb,
    input  logic set_addr,
    input  logic set_btf,
    input  logic set_txe,
    input  logic set_rxne,
    input  logic rd_stat1,
    input  logic rd_stat2,
    input  logic rd_data,
    input  logic wr_data,
    output logic sb_q,
    output logic addr_q,
    output logic btf_q,
    output logic txe_q,
    output logic rxne_q
);

    logic addr_armed;
    logic sb_armed;
    logic addr_clr;
    logic sb_clr;

    // Second step of each two-step clear sequence
    assign addr_clr = rd_stat2 && addr_armed;
    assign sb_clr   = wr_data && sb_armed;

    // Record a status-1 read that saw a flag set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_armed <= 1'b0;
            sb_armed   <= 1'b0;
        end else begin
            if (addr_clr)
                addr_armed <= 1'b0;
            else if (rd_stat1 && addr_q)
                addr_armed <= 1'b1;
            if (sb_clr)
                sb_armed <= 1'b0;
            else if (rd_stat1 && sb_q)
                sb_armed <= 1'b1;
        end
    end

    // Sticky flags; a set pulse takes priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q   <= 1'b0;
            addr_q <= 1'b0;
            btf_q  <= 1'b0;
            txe_q  <= 1'b0;
            rxne_q <= 1'b0;
        end else begin
            if (set_sb)                  sb_q   <= 1'b1;
            else if (sb_clr)             sb_q   <= 1'b0;
            if (set_addr)                addr_q <= 1'b1;
            else if (addr_clr)           addr_q <= 1'b0;
            if (set_btf)                 btf_q  <= 1'b1;
            else if (rd_data || wr_data) btf_q  <= 1'b0;
            if (set_txe)                 txe_q  <= 1'b1;
            else if (wr_data)            txe_q  <= 1'b0;
            if (set_rxne)                rxne_q <= 1'b1;
            else if (rd_data)            rxne_q <= 1'b0;
        end
    end

    AST_ADDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q && !rd_stat2 |=> addr_q); // R8
    AST_ADDR_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q && rd_stat2 && !addr_armed |=> addr_q); // R8
    AST_SB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sb_q && !wr_data |=> sb_q); // R9
    AST_TXE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        txe_q && wr_data && !set_txe |=> !txe_q); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_rxne |=> rxne_q); // R11

endmodule

// File: rtl/sif_irq_gate.sv
// Interrupt gating: combines the sticky flags with the three enables to form
// the event and error lines. Purely combinational; clk and rst_n serve the
// assertions only.
module sif_irq_gate
    import i2c_sif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     buf_en,
    input  logic     evt_en,
    input  logic     err_en,
    input  logic     sb_q,
    input  logic     addr_q,
    input  logic     btf_q,
    input  logic     txe_q,
    input  logic     rxne_q,
    input  err_vec_t err_q,
    output logic     irq_event,
    output logic     irq_error
);

    logic core_evt;
    logic buf_evt;

    // Event sources, with the buffer pair gated by its own enable
    always_comb begin
        core_evt  = sb_q || addr_q || btf_q;
        buf_evt   = buf_en && (txe_q || rxne_q);
        irq_event = evt_en && (core_evt || buf_evt);
        irq_error = err_en && (|err_q);
    end

    AST_BUF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en && !sb_q && !addr_q && !btf_q |-> !irq_event); // R5
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !err_en |-> !irq_error); // R6

endmodule

// File: rtl/i2c_status_irq.sv
// I2C status and interrupt flag unit, top level. Decodes the register bus,
// holds control register 2 and the transmit byte, and builds the read mux.
// Read data is combinational; side effects happen on a strobe.
// Assumes that strobes last one cycle and that DATA_W is at least 11.
module i2c_status_irq
    import i2c_sif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              set_sb,
    input  logic              set_addr,
    input  logic              set_btf,
    input  logic              set_txe,
    input  logic              set_rxne,
    input  logic              set_af,
    input  logic              set_arlo,
    input  logic              set_berr,
    input  logic              bus_busy,
    input  logic [7:0]        rx_data,
    output logic [7:0]        tx_data,
    output logic              irq_event,
    output logic              irq_error
);

    localparam logic [ADDR_W-1:0] A_CTRL2 = ADDR_W'(OFS_CTRL2);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(OFS_STAT1);
    localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(OFS_STAT2);

    ctrl2_t   ctrl2;
    err_vec_t err_q;
    err_vec_t keep_vec;
    logic     sb_q, addr_q, btf_q, txe_q, rxne_q;
    logic     wr_ctrl2, wr_stat1, wr_data, rd_stat1, rd_stat2, rd_data;
    logic     unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:B_AF+1];

    // Register access decode
    always_comb begin
        wr_ctrl2 = reg_wr && (reg_addr == A_CTRL2);
        wr_stat1 = reg_wr && (reg_addr == A_STAT1);
        wr_data  = reg_wr && (reg_addr == A_DATA);
        rd_stat1 = reg_rd && (reg_addr == A_STAT1);
        rd_stat2 = reg_rd && (reg_addr == A_STAT2);
        rd_data  = reg_rd && (reg_addr == A_DATA);
        keep_vec = {reg_wdata[B_AF], reg_wdata[B_ARLO], reg_wdata[B_BERR]};
    end

    // Control register 2 storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl2 <= '0;
        else if (wr_ctrl2)
            ctrl2 <= '{buf_en: reg_wdata[B_BUFEN], evt_en: reg_wdata[B_EVTEN],
                       err_en: reg_wdata[B_ERREN], freq: reg_wdata[FREQ_W-1:0]};
    end

    // Transmit byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_data <= '0;
        else if (wr_data)
            tx_data <= reg_wdata[7:0];
    end

    sif_err_flags u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  ({set_af, set_arlo, set_berr}),
        .wr_stat1 (wr_stat1),
        .keep_vec (keep_vec),
        .q        (err_q)
    );

    sif_evt_flags u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_sb   (set_sb),
        .set_addr (set_addr),
        .set_btf  (set_btf),
        .set_txe  (set_txe),
        .set_rxne (set_rxne),
        .rd_stat1 (rd_stat1),
        .rd_stat2 (rd_stat2),
        .rd_data  (rd_data),
        .wr_data  (wr_data),
        .sb_q     (sb_q),
        .addr_q   (addr_q),
        .btf_q    (btf_q),
        .txe_q    (txe_q),
        .rxne_q   (rxne_q)
    );

    sif_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_en    (ctrl2.buf_en),
        .evt_en    (ctrl2.evt_en),
        .err_en    (ctrl2.err_en),
        .sb_q      (sb_q),
        .addr_q    (addr_q),
        .btf_q     (btf_q),
        .txe_q     (txe_q),
        .rxne_q    (rxne_q),
        .err_q     (err_q),
        .irq_event (irq_event),
        .irq_error (irq_error)
    );

    // Read mux; unmapped offsets and unused bits return zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL2: begin
                reg_rdata[B_BUFEN]      = ctrl2.buf_en;
                reg_rdata[B_EVTEN]      = ctrl2.evt_en;
                reg_rdata[B_ERREN]      = ctrl2.err_en;
                reg_rdata[FREQ_W-1:0]   = ctrl2.freq;
            end
            A_DATA:  reg_rdata[7:0] = rx_data;
            A_STAT1: begin
                reg_rdata[B_AF]   = err_q[2];
                reg_rdata[B_ARLO] = err_q[1];
                reg_rdata[B_BERR] = err_q[0];
                reg_rdata[B_TXE]  = txe_q;
                reg_rdata[B_RXNE] = rxne_q;
                reg_rdata[B_BTF]  = btf_q;
                reg_rdata[B_ADDR] = addr_q;
                reg_rdata[B_SB]   = sb_q;
            end
            A_STAT2: reg_rdata[B_BUSY] = bus_busy;
            default: reg_rdata = '0;
        endcase
    end

    AST_CTRL2_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl2 |=> $stable(ctrl2)); // R4
    AST_TXDATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> tx_data == $past(reg_wdata[7:0])); // R12

endmodule

// File: tb/i2c_status_irq_bench.sv
module i2c_status_irq_bench;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [7:0]    set_mask = '0; // {af,arlo,berr,txe,rxne,btf,addr,sb}
    logic          bus_busy = 1'b0;
    logic [7:0]    rx_data = '0;
    logic [7:0]    tx_data;
    logic          irq_event, irq_error;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    i2c_status_irq #(.ADDR_W(AW), .DATA_W(DW)) u_i2c_status_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .set_sb(set_mask[0]), .set_addr(set_mask[1]), .set_btf(set_mask[2]),
        .set_rxne(set_mask[3]), .set_txe(set_mask[4]), .set_berr(set_mask[5]),
        .set_arlo(set_mask[6]), .set_af(set_mask[7]), .bus_busy(bus_busy),
        .rx_data(rx_data), .tx_data(tx_data),
        .irq_event(irq_event), .irq_error(irq_error)
    );

    // Vector: [12:5] set mask, [4:2] enables {buf,evt,err}, [1] irq_event, [0] irq_error
    localparam logic [12:0] VEC [8] = '{
        {8'h01, 3'b010, 1'b1, 1'b0},
        {8'h10, 3'b010, 1'b0, 1'b0},
        {8'h10, 3'b110, 1'b1, 1'b0},
        {8'h08, 3'b100, 1'b0, 1'b0},
        {8'h80, 3'b001, 1'b0, 1'b1},
        {8'h44, 3'b010, 1'b1, 1'b0},
        {8'h22, 3'b011, 1'b1, 1'b1},
        {8'hFF, 3'b000, 1'b0, 1'b0}
    };

    function automatic logic [15:0] mask_to_sr1(input logic [7:0] m);
        return {5'b0, m[7], m[6], m[5], m[4], m[3], 3'b0, m[2], m[1], m[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        set_mask = m;
        @(negedge clk);
        set_mask = '0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Watchdog
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        do_reset();

        // R1: reset state
        peek(8'h14, v); check("R1 sr1", v, 16'h0000);
        peek(8'h04, v); check("R1 ctrl2", v, 16'h0000);
        check("R1 irqs", {irq_event, irq_error}, 2'b00);
        check("R1 tx_data", tx_data, 8'h00);

        // R2 R5 R6: table of flag and enable patterns
        for (int i = 0; i < 8; i++) begin
            do_reset();
            bus_write(8'h04, {5'b0, VEC[i][4:2], 8'h00});
            pulse(VEC[i][12:5]);
            peek(8'h14, v);
            check("R2 sr1 map", v, mask_to_sr1(VEC[i][12:5]));
            check("R5 irq_event", irq_event, VEC[i][1]);
            check("R6 irq_error", irq_error, VEC[i][0]);
        end

        // R2: flags stay set across idle cycles
        repeat (3) @(negedge clk);
        peek(8'h14, v); check("R2 sticky", v, 16'h07C7);

        // R3: busy mirror
        bus_busy = 1'b1; peek(8'h18, v); check("R3 busy", v, 16'h0002);
        bus_busy = 1'b0; peek(8'h18, v); check("R3 idle", v, 16'h0000);

        // R4: control register readback with unused bits masked
        bus_write(8'h04, 16'hFFFF);
        peek(8'h04, v); check("R4 ctrl2", v, 16'h073F);
        bus_write(8'h04, 16'h0215);
        peek(8'h04, v); check("R4 ctrl2b", v, 16'h0215);

        // R7: write-zero clears errors, write-one keeps, data flags untouched
        do_reset();
        pulse(8'hF0);
        bus_write(8'h14, 16'h0200);
        peek(8'h14, v); check("R7 w0c mix", v, 16'h0280);
        bus_write(8'h14, 16'h0000);
        peek(8'h14, v); check("R7 w0c all", v, 16'h0080);

        // R8: address clear needs status-1 then status-2 read
        do_reset();
        pulse(8'h02);
        bus_read(8'h18);
        peek(8'h14, v); check("R8 sr2 alone", v, 16'h0002);
        bus_read(8'h14);
        bus_read(8'h18);
        peek(8'h14, v); check("R8 sequence", v, 16'h0000);

        // R9: start clear needs status-1 read then data write
        do_reset();
        pulse(8'h01);
        bus_write(8'h10, 16'h005A);
        peek(8'h14, v); check("R9 write alone", v, 16'h0001);
        bus_read(8'h14);
        bus_write(8'h10, 16'h003C);
        peek(8'h14, v); check("R9 sequence", v, 16'h0000);

        // R10: data-register access clears data flags
        do_reset();
        pulse(8'h1C);
        bus_write(8'h10, 16'h0011);
        peek(8'h14, v); check("R10 after write", v, 16'h0040);
        pulse(8'h04);
        bus_read(8'h10);
        peek(8'h14, v); check("R10 after read", v, 16'h0000);

        // R11: set wins over a same-cycle clear
        do_reset();
        pulse(8'h88);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 16'h0000; set_mask = 8'h80;
        @(negedge clk);
        reg_wr = 1'b0; set_mask = 8'h08; reg_rd = 1'b1; reg_addr = 8'h10;
        @(negedge clk);
        reg_rd = 1'b0; set_mask = '0;
        peek(8'h14, v); check("R11 set wins", v, 16'h0440);

        // R12: data register and unmapped offsets
        rx_data = 8'hA5;
        peek(8'h10, v); check("R12 rx read", v, 16'h00A5);
        peek(8'h08, v); check("R12 unmapped", v, 16'h0000);
        bus_write(8'h10, 16'hFF3C);
        check("R12 tx_data", tx_data, 8'h3C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule